// File: doc/BRIEF.md
# Output Compare Channel Pair

This block holds two compare channels that watch one shared, free-running count supplied from outside. Each channel owns a compare value. While the channel runs, it inverts its output each time the count reaches that value, so a sequence of compare values rewritten by software yields a PWM-like waveform. Each match also latches a per-channel event flag, which becomes an interrupt request when that channel's interrupt is enabled.

Software reaches the block through a small word-wide register port. One control word carries every per-channel bit for both channels. A separate mode word selects the compare behaviour of each channel. There is one compare word per channel. A compare write either takes effect at once or waits in a shadow register until the count next wraps to zero, so that a new value never lands in the middle of a period. Because the count may be prescaled, it can hold one value for several clock cycles; a match is still acted on only once per count value.

Top module: `ocp_pair`

## Requirements
- R1: After reset both outputs and both interrupt requests are low, and every register reads as zero.
- R2: In mode 0, while a channel runs, its output inverts in the clock cycle after the count first takes a value equal to the active compare value. A count that stays on that value for further cycles causes no further change. In every other running cycle the output holds its level.
- R3: A match sets the channel's event flag. `irq_o[ch]` is high exactly while both that flag and the channel's interrupt-enable bit are set.
- R4: Writing 0 to a flag bit of the control word clears that flag, and writing 1 leaves it unchanged. If a clearing write and a match fall in the same cycle, the flag ends up set.
- R5: While a channel's run bit is 0, it detects no matches, sets no flag and makes no output change.
- R6: While a channel's run bit is 0, its output follows that channel's level bit one cycle later. When the run bit becomes 1, the output starts from that level.
- R7: With the channel's buffer-off bit at 1, a compare write reaches the active compare value in the next cycle.
- R8: With the buffer-off bit at 0, a compare write goes into a shadow register and the compare word keeps reading the old active value. The shadow value becomes active when the count next takes the value 0 as a new value. A match tested in that same zero cycle still uses the old active value.
- R9: The mode word holds one bit per channel at bit position `ch`. 0 selects up-count one-change compare. 1 suppresses matches, so there is no output change and no flag.
- R10: Register map by `addr`: 0 is the control word, 1 is the mode word, and 2+ch is the compare word of channel ch (reads return the active value). In the control word, bit `ch` is the run bit, bit 2+ch is buffer-off, bit 4+ch is interrupt enable, bit 6+ch is the event flag and bit 8+ch is the output level. Other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| count_i | input | 16 | Shared free-running count value |
| wr_en | input | 1 | Register write strobe for the current cycle |
| addr | input | 2 | Register select |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Register read data for `addr` (combinational) |
| wave_o | output | 2 | Channel output levels, bit per channel |
| irq_o | output | 2 | Interrupt requests, bit per channel |

## Verification
Two pairs of functions can meet in one cycle. The first pair is a software write that clears the event flag and a match that sets it. The bench provokes this by issuing the clearing control write in the very cycle the count steps onto the compare value, then judges it by reading the flag back and watching the interrupt, which must both stay set. The second pair is the shadow-to-active transfer at the count's zero value and a match test on that same zero. The bench sweeps every buffered compare value from 0 to 15 across full count laps and requires the zero cycle to act on the old active value, with the new value taking effect only from the next lap.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

  // Fields of the shared control word; each field is NCH bits wide.
  typedef enum int {
    FLD_RUN  = 0,
    FLD_BDIS = 1,
    FLD_IEN  = 2,
    FLD_FLAG = 3,
    FLD_LVL  = 4
  } ocp_fld_e;

  localparam int OCP_NFLD      = 5;
  localparam int OCP_ADDR_CTL  = 0;
  localparam int OCP_ADDR_MODE = 1;
  localparam int OCP_ADDR_CMP0 = 2;

  // Bit position of one channel's bit inside the control word.
  function automatic int fld_pos(ocp_fld_e f, int ch, int nch);
    return nch * int'(f) + ch;
  endfunction

  // Next output level: forced to the level bit when stopped, inverted on a hit.
  function automatic logic wave_next(logic run, logic lvl, logic hit, logic cur);
    return run ? (cur ^ hit) : lvl;
  endfunction

  // Next event flag: a written 0 clears, a written 1 keeps, a hit always sets.
  function automatic logic flag_next(logic cur, logic we, logic wbit, logic hit);
    return (we ? (cur & wbit) : cur) | hit;
  endfunction

  // A compare hit needs a fresh count value equal to the active compare value.
  function automatic logic hit_test(logic run, logic mode, logic fresh, logic eq);
    return run & ~mode & fresh & eq;
  endfunction

endpackage

// File: rtl/ocp_count_watch.sv
module ocp_count_watch #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count_i,
  output logic          fresh_o,
  output logic          zero_o
);

  logic [CW-1:0] prev_q;
  logic          seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      seen_q <= 1'b0;
    end else begin
      prev_q <= count_i;
      seen_q <= 1'b1;
    end
  end

  // First cycle after reset, or a count differing from last cycle's.
  assign fresh_o = !seen_q || (count_i != prev_q);
  assign zero_o  = fresh_o && (count_i == '0);

endmodule

// File: rtl/ocp_channel.sv
module ocp_channel
  import ocp_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count_i,
  input  logic          fresh_i,
  input  logic          zero_i,
  input  logic          ctl_we,
  input  logic          w_run,
  input  logic          w_bdis,
  input  logic          w_ien,
  input  logic          w_flag,
  input  logic          w_lvl,
  input  logic          mode_we,
  input  logic          w_mode,
  input  logic          cmp_we,
  input  logic [CW-1:0] cmp_d,
  output logic          run_o,
  output logic          bdis_o,
  output logic          ien_o,
  output logic          flag_o,
  output logic          lvl_o,
  output logic          mode_o,
  output logic [CW-1:0] active_o,
  output logic          wave_o,
  output logic          irq_o,
  output logic          match_o
);

  logic          run_q, bdis_q, ien_q, flag_q, lvl_q, mode_q, wave_q, pend_q;
  logic [CW-1:0] active_q, shadow_q;
  logic          xfer;

  assign match_o = hit_test(run_q, mode_q, fresh_i, count_i == active_q);
  assign xfer    = zero_i && pend_q;

  // Control bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      bdis_q <= 1'b0;
      ien_q  <= 1'b0;
      lvl_q  <= 1'b0;
    end else if (ctl_we) begin
      run_q  <= w_run;
      bdis_q <= w_bdis;
      ien_q  <= w_ien;
      lvl_q  <= w_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= 1'b0;
    else if (mode_we) mode_q <= w_mode;
  end

  // Event flag and output level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      wave_q <= 1'b0;
    end else begin
      flag_q <= flag_next(flag_q, ctl_we, w_flag, match_o);
      wave_q <= wave_next(run_q, lvl_q, match_o, wave_q);
    end
  end

  // Compare value with shadow register; transfer on a fresh zero count
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= '0;
      shadow_q <= '0;
      pend_q   <= 1'b0;
    end else if (cmp_we && bdis_q) begin
      active_q <= cmp_d;
      shadow_q <= cmp_d;
      pend_q   <= 1'b0;
    end else if (cmp_we) begin
      shadow_q <= cmp_d;
      pend_q   <= 1'b1;
      if (xfer) active_q <= shadow_q;
    end else if (xfer) begin
      active_q <= shadow_q;
      pend_q   <= 1'b0;
    end
  end

  assign run_o    = run_q;
  assign bdis_o   = bdis_q;
  assign ien_o    = ien_q;
  assign flag_o   = flag_q;
  assign lvl_o    = lvl_q;
  assign mode_o   = mode_q;
  assign active_o = active_q;
  assign wave_o   = wave_q;
  assign irq_o    = flag_q && ien_q;

endmodule

// File: rtl/ocp_regif.sv
module ocp_regif
  import ocp_pkg::*;
#(
  parameter int CW  = 16,
  parameter int NCH = 2,
  parameter int AW  = 2
) (
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [CW-1:0]     wdata,
  input  logic [NCH-1:0]    run_i,
  input  logic [NCH-1:0]    bdis_i,
  input  logic [NCH-1:0]    ien_i,
  input  logic [NCH-1:0]    flag_i,
  input  logic [NCH-1:0]    lvl_i,
  input  logic [NCH-1:0]    mode_i,
  input  logic [NCH*CW-1:0] active_i,
  output logic              ctl_we_o,
  output logic              mode_we_o,
  output logic [NCH-1:0]    cmp_we_o,
  output logic [NCH-1:0]    w_run_o,
  output logic [NCH-1:0]    w_bdis_o,
  output logic [NCH-1:0]    w_ien_o,
  output logic [NCH-1:0]    w_flag_o,
  output logic [NCH-1:0]    w_lvl_o,
  output logic [NCH-1:0]    w_mode_o,
  output logic [CW-1:0]     rdata_o
);

  assign ctl_we_o  = wr_en && (addr == AW'(OCP_ADDR_CTL));
  assign mode_we_o = wr_en && (addr == AW'(OCP_ADDR_MODE));

  for (genvar ch = 0; ch < NCH; ch++) begin : g_dec
    localparam int P_RUN  = fld_pos(FLD_RUN,  ch, NCH);
    localparam int P_BDIS = fld_pos(FLD_BDIS, ch, NCH);
    localparam int P_IEN  = fld_pos(FLD_IEN,  ch, NCH);
    localparam int P_FLAG = fld_pos(FLD_FLAG, ch, NCH);
    localparam int P_LVL  = fld_pos(FLD_LVL,  ch, NCH);
    assign w_run_o[ch]  = wdata[P_RUN];
    assign w_bdis_o[ch] = wdata[P_BDIS];
    assign w_ien_o[ch]  = wdata[P_IEN];
    assign w_flag_o[ch] = wdata[P_FLAG];
    assign w_lvl_o[ch]  = wdata[P_LVL];
    assign w_mode_o[ch] = wdata[ch];
    assign cmp_we_o[ch] = wr_en && (addr == AW'(OCP_ADDR_CMP0 + ch));
  end

  always_comb begin
    rdata_o = '0;
    if (addr == AW'(OCP_ADDR_CTL)) begin
      for (int c = 0; c < NCH; c++) begin
        rdata_o[fld_pos(FLD_RUN,  c, NCH)] = run_i[c];
        rdata_o[fld_pos(FLD_BDIS, c, NCH)] = bdis_i[c];
        rdata_o[fld_pos(FLD_IEN,  c, NCH)] = ien_i[c];
        rdata_o[fld_pos(FLD_FLAG, c, NCH)] = flag_i[c];
        rdata_o[fld_pos(FLD_LVL,  c, NCH)] = lvl_i[c];
      end
    end else if (addr == AW'(OCP_ADDR_MODE)) begin
      rdata_o[NCH-1:0] = mode_i;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (addr == AW'(OCP_ADDR_CMP0 + c)) rdata_o = active_i[c*CW +: CW];
      end
    end
  end

endmodule

// File: rtl/ocp_pair.sv
module ocp_pair
  import ocp_pkg::*;
#(
  parameter int CW  = 16,
  parameter int NCH = 2,
  localparam int AW = $clog2(NCH + OCP_ADDR_CMP0)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CW-1:0]  count_i,
  input  logic           wr_en,
  input  logic [AW-1:0]  addr,
  input  logic [CW-1:0]  wdata,
  output logic [CW-1:0]  rdata,
  output logic [NCH-1:0] wave_o,
  output logic [NCH-1:0] irq_o
);

  // Named internal events, brought out for the checker.
  logic              fresh_w, zero_w;
  logic              ctl_we_w, mode_we_w;
  logic [NCH-1:0]    cmp_we_w, match_w;
  logic [NCH-1:0]    w_run, w_bdis, w_ien, w_flag, w_lvl, w_mode;
  logic [NCH-1:0]    run_w, bdis_w, ien_w, flag_w, lvl_w, mode_w;
  logic [NCH*CW-1:0] active_w;

  ocp_count_watch #(.CW(CW)) u_watch (
    .clk     (clk),
    .rst_n   (rst_n),
    .count_i (count_i),
    .fresh_o (fresh_w),
    .zero_o  (zero_w)
  );

  ocp_regif #(.CW(CW), .NCH(NCH), .AW(AW)) u_regif (
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .run_i     (run_w),
    .bdis_i    (bdis_w),
    .ien_i     (ien_w),
    .flag_i    (flag_w),
    .lvl_i     (lvl_w),
    .mode_i    (mode_w),
    .active_i  (active_w),
    .ctl_we_o  (ctl_we_w),
    .mode_we_o (mode_we_w),
    .cmp_we_o  (cmp_we_w),
    .w_run_o   (w_run),
    .w_bdis_o  (w_bdis),
    .w_ien_o   (w_ien),
    .w_flag_o  (w_flag),
    .w_lvl_o   (w_lvl),
    .w_mode_o  (w_mode),
    .rdata_o   (rdata)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    ocp_channel #(.CW(CW)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .count_i  (count_i),
      .fresh_i  (fresh_w),
      .zero_i   (zero_w),
      .ctl_we   (ctl_we_w),
      .w_run    (w_run[ch]),
      .w_bdis   (w_bdis[ch]),
      .w_ien    (w_ien[ch]),
      .w_flag   (w_flag[ch]),
      .w_lvl    (w_lvl[ch]),
      .mode_we  (mode_we_w),
      .w_mode   (w_mode[ch]),
      .cmp_we   (cmp_we_w[ch]),
      .cmp_d    (wdata),
      .run_o    (run_w[ch]),
      .bdis_o   (bdis_w[ch]),
      .ien_o    (ien_w[ch]),
      .flag_o   (flag_w[ch]),
      .lvl_o    (lvl_w[ch]),
      .mode_o   (mode_w[ch]),
      .active_o (active_w[ch*CW +: CW]),
      .wave_o   (wave_o[ch]),
      .irq_o    (irq_o[ch]),
      .match_o  (match_w[ch])
    );
  end

endmodule

// File: rtl/ocp_pair_chk.sv
module ocp_pair_chk #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           fresh,
  input logic [NCH-1:0] match,
  input logic [NCH-1:0] run,
  input logic [NCH-1:0] lvl,
  input logic [NCH-1:0] flag,
  input logic [NCH-1:0] mode,
  input logic [NCH-1:0] wave
);

  for (genvar c = 0; c < NCH; c++) begin : g_a
    AST_MATCH_ONLY_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
      !fresh |-> !match[c]); // R2
    AST_MATCH_INVERTS: assert property (@(posedge clk) disable iff (!rst_n)
      match[c] |=> (wave[c] != $past(wave[c]))); // R2
    AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (run[c] && !match[c]) |=> $stable(wave[c])); // R2
    AST_MATCH_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      match[c] |=> flag[c]); // R4
    AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !run[c] |-> !match[c]); // R5
    AST_STOPPED_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      !run[c] |=> (wave[c] == $past(lvl[c]))); // R6
    AST_MODE_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
      mode[c] |-> !match[c]); // R9
  end

endmodule

bind ocp_pair ocp_pair_chk #(.NCH(NCH)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .fresh (fresh_w),
  .match (match_w),
  .run   (run_w),
  .lvl   (lvl_w),
  .flag  (flag_w),
  .mode  (mode_w),
  .wave  (wave_o)
);

// File: tb/ocp_pair_test.sv
module ocp_pair_test;

  localparam int CW  = 16;
  localparam int NCH = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] count_i = '0;
  logic          wr_en = 1'b0;
  logic [1:0]    addr = '0;
  logic [CW-1:0] wdata = '0;
  logic [CW-1:0] rdata;
  logic [NCH-1:0] wave_o, irq_o;

  ocp_pair #(.CW(CW), .NCH(NCH)) uut (
    .clk(clk), .rst_n(rst_n), .count_i(count_i), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .wave_o(wave_o), .irq_o(irq_o)
  );

  always #10 clk = ~clk;  // 50 MHz

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  string tag = "R1";

  // Reference state derived from the requirements
  logic [NCH-1:0] m_run, m_bdis, m_ien, m_flag, m_lvl, m_mode, m_wave, m_pend;
  logic [CW-1:0]  m_act [NCH];
  logic [CW-1:0]  m_shd [NCH];
  logic [CW-1:0]  m_prev;
  logic           m_seen;

  task automatic chk(input bit ok, input string t, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] pack_ctl();
    logic [CW-1:0] v = '0;
    v[1:0] = m_run; v[3:2] = m_bdis; v[5:4] = m_ien;
    v[7:6] = m_flag; v[9:8] = m_lvl;
    return v;
  endfunction

  task automatic model_reset();
    m_run = '0; m_bdis = '0; m_ien = '0; m_flag = '0; m_lvl = '0;
    m_mode = '0; m_wave = '0; m_pend = '0; m_prev = '0; m_seen = 1'b0;
    for (int c = 0; c < NCH; c++) begin m_act[c] = '0; m_shd[c] = '0; end
  endtask

  task automatic model_step(input logic [CW-1:0] cnt, input logic we,
                            input logic [1:0] a, input logic [CW-1:0] d);
    logic fresh, zero, hit;
    fresh = !m_seen || (cnt != m_prev);
    zero  = fresh && (cnt == 0);
    for (int c = 0; c < NCH; c++) begin
      hit = m_run[c] && !m_mode[c] && fresh && (cnt == m_act[c]);
      if (!m_run[c]) m_wave[c] = m_lvl[c];
      else if (hit)  m_wave[c] = ~m_wave[c];
      if (we && a == 2'd0) m_flag[c] = (m_flag[c] & d[6+c]) | hit;
      else                 m_flag[c] = m_flag[c] | hit;
      if (we && a == 2'(2 + c)) begin
        if (m_bdis[c]) begin
          m_act[c] = d; m_shd[c] = d; m_pend[c] = 1'b0;
        end else begin
          if (zero && m_pend[c]) m_act[c] = m_shd[c];
          m_shd[c] = d; m_pend[c] = 1'b1;
        end
      end else if (zero && m_pend[c]) begin
        m_act[c] = m_shd[c]; m_pend[c] = 1'b0;
      end
    end
    if (we && a == 2'd0) begin
      m_run = d[1:0]; m_bdis = d[3:2]; m_ien = d[5:4]; m_lvl = d[9:8];
    end
    if (we && a == 2'd1) m_mode = d[1:0];
    m_prev = cnt; m_seen = 1'b1;
  endtask

  // One clock cycle with the given inputs; outputs checked after the edge.
  task automatic cyc(input logic [CW-1:0] cnt, input logic we,
                     input logic [1:0] a, input logic [CW-1:0] d);
    @(negedge clk);
    count_i = cnt; wr_en = we; addr = a; wdata = d;
    @(posedge clk);
    #1;
    model_step(cnt, we, a, d);
    for (int c = 0; c < NCH; c++) begin
      chk(wave_o[c] == m_wave[c], tag, $sformatf("wave ch%0d", c), wave_o[c], m_wave[c]);
      chk(irq_o[c] == (m_flag[c] & m_ien[c]), "R3", $sformatf("irq ch%0d", c),
          irq_o[c], m_flag[c] & m_ien[c]);
    end
  endtask

  task automatic rd_one(input logic [1:0] a, input logic [CW-1:0] exp, input string t);
    wr_en = 1'b0; addr = a;
    #1;
    chk(rdata == exp, t, $sformatf("read addr %0d", a), rdata, exp);
  endtask

  task automatic rd_all(input string t);
    rd_one(2'd0, pack_ctl(), t);
    rd_one(2'd1, {{(CW-NCH){1'b0}}, m_mode}, t);
    rd_one(2'd2, m_act[0], t);
    rd_one(2'd3, m_act[1], t);
  endtask

  task automatic sweep(input int lo, input int hi, input int hold);
    for (int v = lo; v <= hi; v++)
      for (int h = 0; h < hold; h++) cyc(CW'(v), 1'b0, 2'd0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    tag = "R1";
    chk(wave_o == '0, "R1", "wave after reset", wave_o, 0);
    chk(irq_o == '0, "R1", "irq after reset", irq_o, 0);
    rd_all("R1");

    // R6: stopped output follows level bits
    tag = "R6";
    cyc(16'd0, 1'b1, 2'd0, 16'h0300);
    cyc(16'd0, 1'b0, 2'd0, '0);
    rd_all("R10");

    // R7: direct compare writes (buffer off, irq on ch0 only, stopped)
    tag = "R7";
    cyc(16'd0, 1'b1, 2'd0, 16'h001C);
    cyc(16'd0, 1'b1, 2'd2, 16'd5);
    cyc(16'd0, 1'b1, 2'd3, 16'd9);
    rd_all("R7");

    // R5: no matches while stopped
    tag = "R5";
    sweep(0, 15, 2);
    rd_all("R5");

    // R2/R3: running, repeated laps with a prescaled count
    tag = "R2";
    cyc(16'd15, 1'b1, 2'd0, 16'h001F);
    for (int lap = 0; lap < 2; lap++) sweep(0, 31, 3);
    rd_all("R3");

    // R4: writing 1 to flags keeps them, writing 0 clears
    tag = "R4";
    cyc(16'd31, 1'b1, 2'd0, 16'h00DF);
    rd_all("R4");
    cyc(16'd31, 1'b1, 2'd0, 16'h001F);
    rd_all("R4");
    // R4: clearing write in the same cycle as a match on ch0
    cyc(16'd4, 1'b0, 2'd0, '0);
    cyc(16'd5, 1'b1, 2'd0, 16'h001F);
    chk(irq_o[0] == 1'b1, "R4", "flag set wins over clear", irq_o[0], 1);
    rd_all("R4");

    // R9: mode 1 on ch1 suppresses its compare
    tag = "R9";
    cyc(16'd5, 1'b1, 2'd1, 16'h0002);
    sweep(6, 31, 1);
    sweep(0, 15, 1);
    rd_all("R9");
    cyc(16'd15, 1'b1, 2'd1, 16'h0000);

    // R8: buffered writes wait for the zero count
    tag = "R8";
    cyc(16'd15, 1'b1, 2'd0, 16'h0013);
    cyc(16'd15, 1'b1, 2'd2, 16'd12);
    cyc(16'd15, 1'b1, 2'd3, 16'd0);
    rd_all("R8");
    sweep(16, 31, 2);
    rd_all("R8");
    sweep(0, 31, 2);
    rd_all("R8");
    sweep(0, 3, 2);
    // near-exhaustive: every buffered value 0..15 across full laps
    for (int v = 0; v < 16; v++) begin
      cyc(16'd3, 1'b1, 2'd2, CW'(v));
      sweep(4, 19, 1);
      sweep(0, 19, 2);
      sweep(0, 3, 1);
    end
    rd_all("R8");

    // R7: same sweep with buffering off
    tag = "R7";
    cyc(16'd3, 1'b1, 2'd0, 16'h001F);
    for (int v = 0; v < 16; v++) begin
      cyc(16'd3, 1'b1, 2'd3, CW'(v));
      rd_one(2'd3, CW'(v), "R7");
      sweep(4, 19, 1);
      sweep(0, 3, 1);
    end

    // R6: stop forces the level, restart begins from it
    tag = "R6";
    cyc(16'd3, 1'b1, 2'd0, 16'h021C);
    cyc(16'd3, 1'b0, 2'd0, '0);
    chk(wave_o == 2'b10, "R6", "forced level", wave_o, 2);
    cyc(16'd3, 1'b1, 2'd0, 16'h021F);
    sweep(4, 19, 2);
    sweep(0, 19, 2);
    rd_all("R10");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule